// File: doc/BRIEF.md
# Mixed-Width Dual-Port Block Memory

This block is a synchronous two-port memory that holds 36,864 bits. Of these, 32,768 are data bits and 4,096 are parity bits. Each port has its own width, chosen at build time from 1, 2, 4, 9, 18 or 36 bits. Both ports address one shared bit-level space, so a narrow port can read words that a wide port wrote, and the reverse also works. The 9, 18 and 36-bit widths add one parity bit for every 8 data bits. These parity bits sit on a separate lane of each port.

Each port has an enable, a write enable, a full 15-bit address, data and parity inputs, and registered data and parity outputs. A wider port ignores the low address bits that select inside its own word. A build-time mode sets what each port's output shows during a write: the new data, the old contents, or the unchanged previous output. Both ports are sampled on one shared clock. Output registers clear on an asynchronous active-low reset. The array contents are not reset. This document does not define the result when both ports touch the same cell on the same edge.

Top module: `mixed_dpram`

## Requirements
- R1: A port of width W uses only address bits 14 down to log2(D), where D is its data width (1, 2, 4, 8, 16 or 32 for W = 1, 2, 4, 9, 18, 36). Two addresses that differ only in the lower bits select the same word.
- R2: The data lanes of a word at word address M are the 1-bit cells M*D to M*D+D-1, with data bit k at cell M*D+k. A value written through one width reads back through any other width with this mapping.
- R3: Parity exists only for widths 9, 18 and 36. Parity bit j of the word at word address M is parity cell M*(W/9)+j. For widths 1, 2 and 4 the parity output is always 0.
- R4: On an enabled edge with write enable low, the outputs take the word at the address presented on that edge. The new value is visible after that edge.
- R5: In write-first mode, an enabled write puts the input data and parity on the outputs.
- R6: In read-first mode, an enabled write puts on the outputs the contents that the word held before the write.
- R7: In no-change mode, an enabled write leaves the outputs unchanged.
- R8: With the enable low, the port writes nothing and its outputs hold, whatever the write enable is.
- R9: While reset is low, all data and parity outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous active-low reset of the output registers |
| a_en | input | 1 | Port A enable |
| a_we | input | 1 | Port A write enable |
| a_addr | input | 15 | Port A bit-level address |
| a_din | input | data_w(WIDTH_A) | Port A write data |
| a_pin | input | max(1, parity lanes A) | Port A write parity |
| a_dout | output | data_w(WIDTH_A) | Port A registered read data |
| a_pout | output | max(1, parity lanes A) | Port A registered read parity |
| b_en | input | 1 | Port B enable |
| b_we | input | 1 | Port B write enable |
| b_addr | input | 15 | Port B bit-level address |
| b_din | input | data_w(WIDTH_B) | Port B write data |
| b_pin | input | max(1, parity lanes B) | Port B write parity |
| b_dout | output | data_w(WIDTH_B) | Port B registered read data |
| b_pout | output | max(1, parity lanes B) | Port B registered read parity |

## Verification
Suppose the lane offset or the row index is decoded wrongly. The write still lands, but in the wrong cells. The error then shows on the first later read that reaches the intended cells through either port. With a small, dense address window this read comes within a few cycles. A wrong write-mode selection, or an enable that leaks, shows on the output register one edge after the write or idle cycle. Parity misplaced between lanes shows only when a port of a different parity width reads it. For that reason, each bench pairs a wide parity port with a narrower one.

// File: rtl/mdp_pkg.sv
package mdp_pkg;
    localparam int ADDR_W   = 15;
    localparam int ROW_DW   = 32;
    localparam int ROW_PW   = ROW_DW / 8;
    localparam int ROW_LSB  = $clog2(ROW_DW);
    localparam int ROW_PSEL = $clog2(ROW_PW);
    localparam int ROW_AW   = ADDR_W - ROW_LSB;
    localparam int ROWS     = 1 << ROW_AW;

    typedef enum logic [1:0] {
        WR_FIRST = 2'd0,
        RD_FIRST = 2'd1,
        NO_CHG   = 2'd2
    } wmode_e;

    function automatic int data_w(int w);
        return (w >= 9) ? (w / 9) * 8 : w;
    endfunction

    function automatic int par_w(int w);
        return w - data_w(w);
    endfunction

    function automatic int par_port_w(int w);
        return (par_w(w) == 0) ? 1 : par_w(w);
    endfunction

    function automatic int addr_lsb(int w);
        return $clog2(data_w(w));
    endfunction
endpackage

// File: rtl/mdp_store.sv
module mdp_store
    import mdp_pkg::*;
(
    input  logic              clk,
    input  logic [ROW_AW-1:0] a_row,
    input  logic [ROW_DW-1:0] a_dmask,
    input  logic [ROW_DW-1:0] a_dwr,
    input  logic [ROW_PW-1:0] a_pmask,
    input  logic [ROW_PW-1:0] a_pwr,
    input  logic [ROW_AW-1:0] b_row,
    input  logic [ROW_DW-1:0] b_dmask,
    input  logic [ROW_DW-1:0] b_dwr,
    input  logic [ROW_PW-1:0] b_pmask,
    input  logic [ROW_PW-1:0] b_pwr,
    output logic [ROW_DW-1:0] a_rdat,
    output logic [ROW_PW-1:0] a_rpar,
    output logic [ROW_DW-1:0] b_rdat,
    output logic [ROW_PW-1:0] b_rpar
);
    logic [ROW_DW-1:0] dat_q [ROWS];
    logic [ROW_PW-1:0] par_q [ROWS];

    // Reads see the array as it stood before the current edge.
    assign a_rdat = dat_q[a_row];
    assign a_rpar = par_q[a_row];
    assign b_rdat = dat_q[b_row];
    assign b_rpar = par_q[b_row];

    // Bit-masked writes let both ports update disjoint lanes of one row.
    always_ff @(posedge clk) begin
        for (int i = 0; i < ROW_DW; i++) begin
            if (a_dmask[i]) dat_q[a_row][i] <= a_dwr[i];
            if (b_dmask[i]) dat_q[b_row][i] <= b_dwr[i];
        end
        for (int j = 0; j < ROW_PW; j++) begin
            if (a_pmask[j]) par_q[a_row][j] <= a_pwr[j];
            if (b_pmask[j]) par_q[b_row][j] <= b_pwr[j];
        end
    end
endmodule

// File: rtl/mdp_port.sv
module mdp_port
    import mdp_pkg::*;
#(
    parameter int     WIDTH = 36,
    parameter wmode_e MODE  = WR_FIRST
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         en,
    input  logic                         we,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [data_w(WIDTH)-1:0]     din,
    input  logic [par_port_w(WIDTH)-1:0] pin,
    input  logic [ROW_DW-1:0]            row_dat,
    input  logic [ROW_PW-1:0]            row_par,
    output logic [ROW_AW-1:0]            row_idx,
    output logic [ROW_DW-1:0]            wr_dmask,
    output logic [ROW_DW-1:0]            wr_dat,
    output logic [ROW_PW-1:0]            wr_pmask,
    output logic [ROW_PW-1:0]            wr_par,
    output logic [data_w(WIDTH)-1:0]     dout,
    output logic [par_port_w(WIDTH)-1:0] pout
);
    localparam int DW  = data_w(WIDTH);
    localparam int PW  = par_w(WIDTH);
    localparam int PWP = par_port_w(WIDTH);
    localparam int LSB = addr_lsb(WIDTH);

    typedef struct packed {
        logic [DW-1:0]  dat;
        logic [PWP-1:0] par;
    } out_s;

    out_s st_d, st_q;

    logic [ROW_LSB-1:0] lane;
    logic [ROW_LSB-1:0] doff;
    logic [DW-1:0]      rd_dat;
    logic [PWP-1:0]     rd_par;
    logic               wr;
    logic               unused_sink;

    assign row_idx = addr[ADDR_W-1:ROW_LSB];
    assign lane    = ROW_LSB'(addr[ROW_LSB-1:0] >> LSB);
    assign doff    = ROW_LSB'(int'(lane) * DW);
    assign rd_dat  = row_dat[doff +: DW];
    assign wr      = en & we;

    assign wr_dmask = wr ? (ROW_DW'({DW{1'b1}}) << doff) : '0;
    assign wr_dat   = ROW_DW'(din) << doff;

    generate
        if (PW > 0) begin : g_par
            logic [ROW_PSEL-1:0] poff;
            assign poff     = ROW_PSEL'(int'(lane) * PW);
            assign rd_par   = row_par[poff +: PW];
            assign wr_pmask = wr ? (ROW_PW'({PW{1'b1}}) << poff) : '0;
            assign wr_par   = ROW_PW'(pin) << poff;
        end else begin : g_nopar
            assign rd_par   = '0;
            assign wr_pmask = '0;
            assign wr_par   = '0;
        end
    endgenerate

    assign unused_sink = ^{addr, pin, row_par};

    always_comb begin
        st_d = st_q;
        if (en) begin
            if (!we) begin
                st_d.dat = rd_dat;
                st_d.par = rd_par;
            end else if (MODE == WR_FIRST) begin
                st_d.dat = din;
                st_d.par = (PW > 0) ? pin : '0;
            end else if (MODE == RD_FIRST) begin
                st_d.dat = rd_dat;
                st_d.par = rd_par;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.dat;
    assign pout = st_q.par;

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(dout) && $stable(pout)));

    generate
        if (MODE == WR_FIRST) begin : g_wf_chk
            // R5
            write_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (en && we) |=> (dout == $past(din)));
        end
        if (MODE == NO_CHG) begin : g_nc_chk
            // R7
            write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (en && we) |=> ($stable(dout) && $stable(pout)));
        end
        if (PW == 0) begin : g_np_chk
            // R3
            no_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
                pout == '0);
        end
    endgenerate
endmodule

// File: rtl/mixed_dpram.sv
module mixed_dpram
    import mdp_pkg::*;
#(
    parameter int     WIDTH_A = 36,
    parameter int     WIDTH_B = 9,
    parameter wmode_e MODE_A  = WR_FIRST,
    parameter wmode_e MODE_B  = RD_FIRST
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           a_en,
    input  logic                           a_we,
    input  logic [ADDR_W-1:0]              a_addr,
    input  logic [data_w(WIDTH_A)-1:0]     a_din,
    input  logic [par_port_w(WIDTH_A)-1:0] a_pin,
    output logic [data_w(WIDTH_A)-1:0]     a_dout,
    output logic [par_port_w(WIDTH_A)-1:0] a_pout,
    input  logic                           b_en,
    input  logic                           b_we,
    input  logic [ADDR_W-1:0]              b_addr,
    input  logic [data_w(WIDTH_B)-1:0]     b_din,
    input  logic [par_port_w(WIDTH_B)-1:0] b_pin,
    output logic [data_w(WIDTH_B)-1:0]     b_dout,
    output logic [par_port_w(WIDTH_B)-1:0] b_pout
);
    logic [ROW_AW-1:0] a_row, b_row;
    logic [ROW_DW-1:0] a_dmask, a_dwr, b_dmask, b_dwr, a_rdat, b_rdat;
    logic [ROW_PW-1:0] a_pmask, a_pwr, b_pmask, b_pwr, a_rpar, b_rpar;

    mdp_port #(.WIDTH(WIDTH_A), .MODE(MODE_A)) u_port_a (
        .clk(clk), .rst_n(rst_n), .en(a_en), .we(a_we), .addr(a_addr),
        .din(a_din), .pin(a_pin), .row_dat(a_rdat), .row_par(a_rpar),
        .row_idx(a_row), .wr_dmask(a_dmask), .wr_dat(a_dwr),
        .wr_pmask(a_pmask), .wr_par(a_pwr), .dout(a_dout), .pout(a_pout)
    );

    mdp_port #(.WIDTH(WIDTH_B), .MODE(MODE_B)) u_port_b (
        .clk(clk), .rst_n(rst_n), .en(b_en), .we(b_we), .addr(b_addr),
        .din(b_din), .pin(b_pin), .row_dat(b_rdat), .row_par(b_rpar),
        .row_idx(b_row), .wr_dmask(b_dmask), .wr_dat(b_dwr),
        .wr_pmask(b_pmask), .wr_par(b_pwr), .dout(b_dout), .pout(b_pout)
    );

    mdp_store u_store (
        .clk(clk),
        .a_row(a_row), .a_dmask(a_dmask), .a_dwr(a_dwr),
        .a_pmask(a_pmask), .a_pwr(a_pwr),
        .b_row(b_row), .b_dmask(b_dmask), .b_dwr(b_dwr),
        .b_pmask(b_pmask), .b_pwr(b_pwr),
        .a_rdat(a_rdat), .a_rpar(a_rpar), .b_rdat(b_rdat), .b_rpar(b_rpar)
    );
endmodule

// File: tb/mdp_harness.sv
module mdp_harness #(
    parameter int              WA  = 36,
    parameter int              WB  = 9,
    parameter mdp_pkg::wmode_e MA  = mdp_pkg::WR_FIRST,
    parameter mdp_pkg::wmode_e MB  = mdp_pkg::RD_FIRST,
    parameter int              RUN = 3000
) (
    input  logic clk,
    input  logic rst_n,
    output int   n_chk,
    output int   n_err,
    output logic done
);
    function automatic int f_dw(int w); return (w >= 9) ? (w / 9) * 8 : w; endfunction
    function automatic int f_pw(int w); return w - f_dw(w); endfunction
    function automatic int f_pp(int w); return (f_pw(w) == 0) ? 1 : f_pw(w); endfunction

    localparam int DWA = f_dw(WA), PWA = f_pw(WA), PPA = f_pp(WA);
    localparam int DWB = f_dw(WB), PWB = f_pw(WB), PPB = f_pp(WB);
    localparam int CELLS = 512;

    logic           a_en, a_we, b_en, b_we;
    logic [14:0]    a_addr, b_addr;
    logic [DWA-1:0] a_din, a_dout;
    logic [PPA-1:0] a_pin, a_pout;
    logic [DWB-1:0] b_din, b_dout;
    logic [PPB-1:0] b_pin, b_pout;

    mixed_dpram #(.WIDTH_A(WA), .WIDTH_B(WB), .MODE_A(MA), .MODE_B(MB)) dut (
        .clk(clk), .rst_n(rst_n),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_din(a_din), .a_pin(a_pin),
        .a_dout(a_dout), .a_pout(a_pout),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_din(b_din), .b_pin(b_pin),
        .b_dout(b_dout), .b_pout(b_pout)
    );

    logic        dm [CELLS];
    logic        pm [CELLS/8];
    logic [31:0] ea_d, eb_d;
    logic [3:0]  ea_p, eb_p;
    string       ta, tb;

    function automatic int cell_base(int w, logic [14:0] a);
        return int'(a) & ~(f_dw(w) - 1);
    endfunction

    function automatic logic [31:0] m_rd(int w, logic [14:0] a);
        logic [31:0] v = '0;
        for (int k = 0; k < f_dw(w); k++) v[k] = dm[cell_base(w, a) + k];
        return v;
    endfunction

    function automatic logic [3:0] m_rp(int w, logic [14:0] a);
        logic [3:0] v = '0;
        for (int k = 0; k < f_pw(w); k++) v[k] = pm[cell_base(w, a) / 8 + k];
        return v;
    endfunction

    task automatic m_wr(int w, logic [14:0] a, logic [31:0] d, logic [3:0] p);
        for (int k = 0; k < f_dw(w); k++) dm[cell_base(w, a) + k] = d[k];
        for (int k = 0; k < f_pw(w); k++) pm[cell_base(w, a) / 8 + k] = p[k];
    endtask

    task automatic chk(string nm, string tag, logic [31:0] act_d, logic [31:0] exp_d,
                       logic [3:0] act_p, logic [3:0] exp_p, int pw);
        n_chk++;
        if (act_d !== exp_d) begin
            n_err++;
            $display("FAIL %s port %s data: actual %h expected %h", tag, nm, act_d, exp_d);
        end
        n_chk++;
        if (pw == 0 && act_p !== 4'd0) begin
            n_err++;
            $display("FAIL R3 port %s narrow parity: actual %h expected 0", nm, act_p);
        end else if (pw > 0 && act_p !== exp_p) begin
            n_err++;
            $display("FAIL R3 %s port %s parity: actual %h expected %h", tag, nm, act_p, exp_p);
        end
    endtask

    function automatic string mode_tag(mdp_pkg::wmode_e m);
        if (m == mdp_pkg::WR_FIRST) return "R5 write-first";
        if (m == mdp_pkg::RD_FIRST) return "R6 read-first";
        return "R7 no-change";
    endfunction

    task automatic compare();
        chk("A", ta, 32'(a_dout), ea_d, 4'(a_pout), ea_p, PWA);
        chk("B", tb, 32'(b_dout), eb_d, 4'(b_pout), eb_p, PWB);
    endtask

    initial begin
        int na, nb;
        logic [31:0] ra, rb;
        logic [3:0]  rpa, rpb;
        n_chk = 0; n_err = 0; done = 1'b0;
        a_en = 0; a_we = 0; a_addr = '0; a_din = '0; a_pin = '0;
        b_en = 0; b_we = 0; b_addr = '0; b_din = '0; b_pin = '0;
        ea_d = '0; eb_d = '0; ea_p = '0; eb_p = '0;
        ta = "R9 reset"; tb = "R9 reset";
        for (int i = 0; i < CELLS; i++) dm[i] = 1'b0;
        for (int i = 0; i < CELLS / 8; i++) pm[i] = 1'b0;
        na = CELLS / DWA;
        nb = CELLS / DWB;
        repeat (2) @(negedge clk);
        compare();                                   // R9 outputs clear in reset
        @(posedge rst_n);
        for (int c = 0; c < na + nb + RUN; c++) begin
            @(negedge clk);
            compare();
            a_din = DWA'($urandom); a_pin = PPA'($urandom);
            b_din = DWB'($urandom); b_pin = PPB'($urandom);
            if (c < na) begin                        // fill through A, random low bits (R1)
                a_en = 1; a_we = 1; a_addr = 15'((c * DWA) | int'($urandom % DWA));
                b_en = 0; b_we = 1'($urandom);
            end else if (c < na + nb) begin          // overwrite through B
                a_en = 0; a_we = 1'($urandom);
                b_en = 1; b_we = 1; b_addr = 15'(((c - na) * DWB) | int'($urandom % DWB));
            end else begin
                a_en = ($urandom % 5) != 0; a_we = 1'($urandom);
                b_en = ($urandom % 5) != 0; b_we = 1'($urandom);
                a_addr = 15'($urandom % CELLS);
                b_addr = 15'($urandom % CELLS);
                if (a_en && b_en && (a_we || b_we) &&
                    cell_base(WA, a_addr) < cell_base(WB, b_addr) + DWB &&
                    cell_base(WB, b_addr) < cell_base(WA, a_addr) + DWA)
                    b_en = 0;                        // keep same-cell collisions out
            end
            ra = m_rd(WA, a_addr); rpa = m_rp(WA, a_addr);
            rb = m_rd(WB, b_addr); rpb = m_rp(WB, b_addr);
            if (!a_en) ta = "R8 idle";
            else if (!a_we) begin ta = "R1 R2 R4 read"; ea_d = ra; ea_p = rpa; end
            else begin
                ta = mode_tag(MA);
                if (MA == mdp_pkg::WR_FIRST) begin ea_d = 32'(a_din); ea_p = (PWA > 0) ? 4'(a_pin) : 4'd0; end
                else if (MA == mdp_pkg::RD_FIRST) begin ea_d = ra; ea_p = rpa; end
            end
            if (!b_en) tb = "R8 idle";
            else if (!b_we) begin tb = "R1 R2 R4 read"; eb_d = rb; eb_p = rpb; end
            else begin
                tb = mode_tag(MB);
                if (MB == mdp_pkg::WR_FIRST) begin eb_d = 32'(b_din); eb_p = (PWB > 0) ? 4'(b_pin) : 4'd0; end
                else if (MB == mdp_pkg::RD_FIRST) begin eb_d = rb; eb_p = rpb; end
            end
            if (a_en && a_we) m_wr(WA, a_addr, 32'(a_din), 4'(a_pin));
            if (b_en && b_we) m_wr(WB, b_addr, 32'(b_din), 4'(b_pin));
        end
        @(negedge clk);
        compare();
        done = 1'b1;
    end
endmodule

// File: tb/tb_mixed_dpram.sv
`timescale 1ns/1ps
module tb_mixed_dpram;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   c0, e0, c1, e1;
    logic d0, d1;

    always #5 clk = ~clk;

    // wide write-first against byte-plus-parity read-first
    mdp_harness #(.WA(36), .WB(9), .MA(mdp_pkg::WR_FIRST), .MB(mdp_pkg::RD_FIRST)) h_wide (
        .clk(clk), .rst_n(rst_n), .n_chk(c0), .n_err(e0), .done(d0));

    // half-word write-first against nibble no-change
    mdp_harness #(.WA(18), .WB(4), .MA(mdp_pkg::WR_FIRST), .MB(mdp_pkg::NO_CHG)) h_narrow (
        .clk(clk), .rst_n(rst_n), .n_chk(c1), .n_err(e1), .done(d1));

    initial begin
        int cyc = 0;
        int wd  = 0;
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        while (!(d0 && d1) && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!(d0 && d1)) begin
            wd = 1;
            $display("FAIL R4 watchdog: done actual %0b%0b expected 11", d0, d1);
        end
        $display("CHECKS %0d ERRORS %0d", c0 + c1 + wd, e0 + e1 + wd);
        $finish;
    end
endmodule